// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block draws one solid, axis-aligned rectangle into a pixel framebuffer. A controller supplies the words of a drawing command packet and pulses `start`. The engine checks the command code and decodes two packed corner vertices. Both vertices are first corrected by a signed line-width value, and the height of the rectangle is then stretched by a rounded quarter of that width. The engine also picks a fill value from the attribute word. It then walks the rectangle in row-major order and issues exactly one framebuffer write per clock on a synchronous write port.

Pixels are written either as 24-bit grey triplets or as 8-bit indexed values, chosen per command. While it draws, the engine keeps a running dirty rectangle. This is the bounding box of every column span and row it has touched since reset, and a display refresh stage downstream reads it to limit its work. Fetching the packet from memory and palette lookup take place outside this block.

Top module: `rectfill_engine`

## Requirements
- R1: A command is accepted only on a clock where `start` is high, `pkt_cmd` equals 32'h0000_0411 and the engine is not drawing. Any other start does nothing: no writes occur, `busy` and `done` stay low, and the dirty rectangle is unchanged.
- R2: `pkt_lw` (packet word 4) is subtracted, modulo 2^32, from both `pkt_v1` (word 6) and `pkt_v2` (word 7) before any field is taken. From each corrected vertex, X is bits 29:19 and Y is bits 12:3.
- R3: The rows filled run from y1 up to and excluding y2 + q, where q = (lw + 1) arithmetically shifted right by 2 and lw is treated as signed. Rows at or beyond YSIZE are not drawn.
- R4: The columns filled run from x1 up to and excluding x2. When x2 - x1 (signed) is greater than XSIZE, x2 is replaced by XSIZE.
- R5: In 24-bit mode (`mode_24bpp`=1), `pkt_attr[23:16]` selects the grey level g: 0 gives 0, 7 gives 192, and any other value gives 255. `fb_data` is {g,g,g}.
- R6: In 8-bit mode (`mode_24bpp`=0), `fb_data` is {16'h0000, `pkt_attr[7:0]`}.
- R7: Pixels are written one per clock in row-major order at address y*XSIZE + x. The first write appears in the cycle after the acceptance edge.
- R8: `done` is high for exactly one cycle, in the cycle after the last write. If the rectangle has no columns or no rows, nothing is written and `done` is high in the cycle after acceptance.
- R9: A `start` that arrives while `busy` is high is ignored, and the pixel stream in progress continues unchanged.
- R10: After reset the dirty rectangle is x1=2047, x2=0, y1=1023, y2=0. Each accepted non-empty command widens it to include columns x1..x2 (x2 after the limit of R4) and its first and last drawn rows. An empty command leaves it unchanged.
- R11: A command accepted in the same cycle that `done` is high starts drawing with no idle cycle in between.
- R12: After reset `busy`, `done` and `fb_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the presented packet |
| pkt_cmd | input | 32 | Packet word 0, command code |
| pkt_lw | input | 32 | Packet word 4, signed line width |
| pkt_attr | input | 32 | Packet word 5, attribute |
| pkt_v1 | input | 32 | Packet word 6, first packed vertex |
| pkt_v2 | input | 32 | Packet word 7, second packed vertex |
| mode_24bpp | input | 1 | 1: 24-bit grey pixels, 0: 8-bit pixels |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | ADDR_W (21) | Pixel index y*XSIZE + x |
| fb_data | output | 24 | Pixel value |
| busy | output | 1 | Rectangle being drawn |
| done | output | 1 | One-cycle completion pulse |
| dirty_x1 | output | 11 | Dirty rectangle left column |
| dirty_x2 | output | 11 | Dirty rectangle right limit |
| dirty_y1 | output | 10 | Dirty rectangle top row |
| dirty_y2 | output | 10 | Dirty rectangle bottom row |

## Verification
The completion pulse of one rectangle and the acceptance of the next one can fall in the same cycle. In that cycle the dirty record also widens for the new command while the old one retires. The bench provokes this by raising `start` with a second packet in exactly the cycle where `done` is first seen. It then requires the first pixel of the second rectangle in the very next cycle, and afterwards checks that the dirty record holds the union of both rectangles. A second collision is a `start` raised in the middle of a stream; it is judged by the unchanged pixel sequence that follows.

// File: rtl/rf_pkg.sv
// Shared definitions for the rectangle fill engine: command code, packed
// vertex field positions, the decoded job record and the grey mapping.
// Assumes packets arrive already split into 32-bit words.
package rf_pkg;

    localparam logic [31:0] CMD_FILL = 32'h0000_0411;

    localparam int X_W   = 11;
    localparam int Y_W   = 10;
    localparam int VX_HI = 29;
    localparam int VX_LO = 19;
    localparam int VY_HI = 12;
    localparam int VY_LO = 3;

    localparam logic [7:0] SEL_BLACK = 8'd0;
    localparam logic [7:0] SEL_MID   = 8'd7;
    localparam logic [7:0] LVL_BLACK = 8'd0;
    localparam logic [7:0] LVL_MID   = 8'd192;
    localparam logic [7:0] LVL_FULL  = 8'd255;

    typedef struct packed {
        logic [X_W-1:0] x0;
        logic [X_W-1:0] xe;
        logic [Y_W-1:0] y0;
        logic [Y_W-1:0] ylast;
        logic           empty;
        logic [23:0]    pix;
    } fill_job_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

    // Map the attribute selector to one of three grey levels.
    function automatic logic [7:0] grey_level(input logic [7:0] sel);
        if (sel == SEL_BLACK)
            return LVL_BLACK;
        else if (sel == SEL_MID)
            return LVL_MID;
        else
            return LVL_FULL;
    endfunction

endpackage

// File: rtl/rf_decode.sv
// Combinational decode of one fill packet into a job record.
// Corrects both vertices by the line width, extracts the coordinates,
// limits the column end, stretches the row end by the rounded quarter
// width, clips the rows at the frame bottom and forms the pixel value.
// Assumes XSIZE < 2048 so that the limited column end fits in X_W bits.
module rf_decode
    import rf_pkg::*;
#(
    parameter int XSIZE = 1280,
    parameter int YSIZE = 1024
) (
    input  logic [31:0] lw_word,
    input  logic [31:0] attr_word,
    input  logic [31:0] va_word,
    input  logic [31:0] vb_word,
    input  logic        mode_24,
    output fill_job_t   job
);

    localparam logic signed [12:0] XSIZE_S = 13'(XSIZE);
    localparam logic [X_W-1:0]     XSIZE_X = X_W'(XSIZE);
    localparam logic signed [33:0] YSIZE_S = 34'(YSIZE);

    logic [31:0]        va_c;
    logic [31:0]        vb_c;
    logic [X_W-1:0]     xa;
    logic [X_W-1:0]     xb;
    logic [X_W-1:0]     x_lim;
    logic [Y_W-1:0]     ya;
    logic [Y_W-1:0]     yb;
    logic signed [12:0] span;
    logic signed [33:0] lw_ext;
    logic signed [33:0] lw_q;
    logic signed [33:0] y_end;
    logic signed [33:0] y_lim;
    logic [7:0]         grey;

    // Vertex correction and field extraction.
    always_comb begin
        va_c = va_word - lw_word;
        vb_c = vb_word - lw_word;
        xa   = va_c[VX_HI:VX_LO];
        ya   = va_c[VY_HI:VY_LO];
        xb   = vb_c[VX_HI:VX_LO];
        yb   = vb_c[VY_HI:VY_LO];
    end

    // Column limit: a span wider than the frame ends at XSIZE.
    always_comb begin
        span  = $signed({2'b00, xb}) - $signed({2'b00, xa});
        x_lim = (span > XSIZE_S) ? XSIZE_X : xb;
    end

    // Row end: second Y plus the rounded quarter width, clipped to the frame.
    always_comb begin
        lw_ext = $signed({{2{lw_word[31]}}, lw_word});
        lw_q   = (lw_ext + 34'sd1) >>> 2;
        y_end  = $signed({24'd0, yb}) + lw_q;
        y_lim  = (y_end > YSIZE_S) ? YSIZE_S : y_end;
    end

    // Job record and pixel value.
    always_comb begin
        grey      = grey_level(attr_word[23:16]);
        job.x0    = xa;
        job.xe    = x_lim;
        job.y0    = ya;
        job.ylast = Y_W'(y_lim - 34'sd1);
        job.empty = (x_lim <= xa) || (y_lim <= $signed({24'd0, ya}));
        job.pix   = mode_24 ? {grey, grey, grey} : {16'h0000, attr_word[7:0]};
    end

endmodule

// File: rtl/rf_scan.sv
// Rectangle walker: latches an accepted job and emits one framebuffer
// write per clock in row-major order, then a one-cycle done pulse.
// The row base is formed by one multiply at acceptance and then
// stepped by XSIZE per row. Assumes go is only raised while ready.
module rf_scan
    import rf_pkg::*;
#(
    parameter int XSIZE  = 1280,
    parameter int YSIZE  = 1024,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  fill_job_t         job,
    output logic              ready,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [23:0]       fb_data,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(XSIZE);
    localparam logic [X_W-1:0]    ONE_X    = X_W'(1);
    localparam logic [Y_W-1:0]    ONE_Y    = Y_W'(1);

    scan_state_t       state;
    logic [X_W-1:0]    cx;
    logic [X_W-1:0]    x0;
    logic [X_W-1:0]    xe;
    logic [Y_W-1:0]    cy;
    logic [Y_W-1:0]    ylast;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] row_base;
    logic [23:0]       pix;
    logic [ADDR_W-1:0] start_base;
    logic              row_end;
    logic              frame_end;

    // Row base of the first row of a newly accepted job.
    always_comb begin
        start_base = ADDR_W'(job.y0) * ROW_STEP;
    end

    // Position tests for the current pixel.
    always_comb begin
        row_end   = (cx == xe - ONE_X);
        frame_end = row_end && (cy == ylast);
    end

    // Walker state, pixel position and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cx       <= '0;
            x0       <= '0;
            xe       <= '0;
            cy       <= '0;
            ylast    <= '0;
            addr     <= '0;
            row_base <= '0;
            pix      <= '0;
        end else if (go) begin
            x0       <= job.x0;
            xe       <= job.xe;
            ylast    <= job.ylast;
            cx       <= job.x0;
            cy       <= job.y0;
            pix      <= job.pix;
            row_base <= start_base;
            addr     <= start_base + ADDR_W'(job.x0);
            state    <= job.empty ? ST_DONE : ST_RUN;
        end else begin
            case (state)
                ST_RUN: begin
                    if (frame_end) begin
                        state <= ST_DONE;
                    end else if (row_end) begin
                        cx       <= x0;
                        cy       <= cy + ONE_Y;
                        row_base <= row_base + ROW_STEP;
                        addr     <= row_base + ROW_STEP + ADDR_W'(x0);
                    end else begin
                        cx   <= cx + ONE_X;
                        addr <= addr + ADDR_W'(1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port view of the walker.
    always_comb begin
        ready   = (state != ST_RUN);
        busy    = (state == ST_RUN);
        done    = (state == ST_DONE);
        fb_we   = (state == ST_RUN);
        fb_addr = addr;
        fb_data = pix;
    end

    // R7: consecutive writes move strictly forward through the frame.
    a_r7_addr_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> (fb_addr > $past(fb_addr)));

    // R8: the write stream always ends into a done pulse.
    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fb_we) |-> done);

    // R9: drawing only begins after an accepted request.
    a_r9_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    // R11: a non-empty job taken on the done cycle writes at once.
    a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go && !job.empty) |=> fb_we);

endmodule

// File: rtl/rf_dirty.sv
// Dirty rectangle record: keeps the bounding box of every column span
// and row range drawn since reset. Starts as an inverted (empty) box.
// Assumes each accepted job covers a contiguous block of rows.
module rf_dirty
    import rf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd,
    input  fill_job_t      job,
    output logic [X_W-1:0] dx1,
    output logic [X_W-1:0] dx2,
    output logic [Y_W-1:0] dy1,
    output logic [Y_W-1:0] dy2
);

    // Widen the box to the accepted job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dx1 <= '1;
            dx2 <= '0;
            dy1 <= '1;
            dy2 <= '0;
        end else if (upd) begin
            if (job.x0 < dx1)    dx1 <= job.x0;
            if (job.xe > dx2)    dx2 <= job.xe;
            if (job.y0 < dy1)    dy1 <= job.y0;
            if (job.ylast > dy2) dy2 <= job.ylast;
        end
    end

    // R10: the low edges never move up.
    a_r10_low_edges_shrink_only: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dx1 <= $past(dx1)) && (dy1 <= $past(dy1)));

    // R10: the high edges never move down.
    a_r10_high_edges_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dx2 >= $past(dx2)) && (dy2 >= $past(dy2)));

endmodule

// File: rtl/rectfill_engine.sv
// Top of the solid rectangle fill engine. Gates the start request on
// the command code and the walker being free, decodes the packet,
// drives the framebuffer write port and keeps the dirty record.
// Assumes packet words stay stable during the start cycle.
module rectfill_engine
    import rf_pkg::*;
#(
    parameter int XSIZE = 1280,
    parameter int YSIZE = 1024,
    localparam int ADDR_W = $clog2(XSIZE * YSIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       pkt_cmd,
    input  logic [31:0]       pkt_lw,
    input  logic [31:0]       pkt_attr,
    input  logic [31:0]       pkt_v1,
    input  logic [31:0]       pkt_v2,
    input  logic              mode_24bpp,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [23:0]       fb_data,
    output logic              busy,
    output logic              done,
    output logic [10:0]       dirty_x1,
    output logic [10:0]       dirty_x2,
    output logic [9:0]        dirty_y1,
    output logic [9:0]        dirty_y2
);

    fill_job_t job;
    logic      ready;
    logic      accept;

    // Acceptance: right code, start raised, walker free.
    always_comb begin
        accept = start && (pkt_cmd == CMD_FILL) && ready;
    end

    rf_decode #(
        .XSIZE (XSIZE),
        .YSIZE (YSIZE)
    ) u_decode (
        .lw_word   (pkt_lw),
        .attr_word (pkt_attr),
        .va_word   (pkt_v1),
        .vb_word   (pkt_v2),
        .mode_24   (mode_24bpp),
        .job       (job)
    );

    rf_scan #(
        .XSIZE  (XSIZE),
        .YSIZE  (YSIZE),
        .ADDR_W (ADDR_W)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (accept),
        .job     (job),
        .ready   (ready),
        .fb_we   (fb_we),
        .fb_addr (fb_addr),
        .fb_data (fb_data),
        .busy    (busy),
        .done    (done)
    );

    rf_dirty u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (accept && !job.empty),
        .job   (job),
        .dx1   (dirty_x1),
        .dx2   (dirty_x2),
        .dy1   (dirty_y1),
        .dy2   (dirty_y2)
    );

    // R1: drawing starts only after a start carrying the fill code.
    a_r1_cmd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && (pkt_cmd == CMD_FILL)));

    // R12: write strobe and completion never overlap.
    a_r12_we_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fb_we);

endmodule

// File: tb/tb_rectfill_engine.sv
module tb_rectfill_engine;

    localparam int XS = 1280;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pkt_cmd = '0;
    logic [31:0] pkt_lw = '0;
    logic [31:0] pkt_attr = '0;
    logic [31:0] pkt_v1 = '0;
    logic [31:0] pkt_v2 = '0;
    logic        mode_24bpp = 1'b0;
    logic        fb_we;
    logic [20:0] fb_addr;
    logic [23:0] fb_data;
    logic        busy;
    logic        done;
    logic [10:0] dirty_x1;
    logic [10:0] dirty_x2;
    logic [9:0]  dirty_y1;
    logic [9:0]  dirty_y2;

    int n_checks = 0;
    int n_fail   = 0;
    int ex1 = 2047, ex2 = 0, ey1 = 1023, ey2 = 0;

    always #10 clk = ~clk;

    rectfill_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_cmd(pkt_cmd),
        .pkt_lw(pkt_lw), .pkt_attr(pkt_attr), .pkt_v1(pkt_v1), .pkt_v2(pkt_v2),
        .mode_24bpp(mode_24bpp), .fb_we(fb_we), .fb_addr(fb_addr),
        .fb_data(fb_data), .busy(busy), .done(done),
        .dirty_x1(dirty_x1), .dirty_x2(dirty_x2),
        .dirty_y1(dirty_y1), .dirty_y2(dirty_y2)
    );

    function automatic logic [31:0] mkv(input int x, input int y);
        return (32'(x) << 19) | (32'(y) << 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic dirty_add(input int x0, input int xe, input int y0, input int yl);
        if (x0 < ex1) ex1 = x0;
        if (xe > ex2) ex2 = xe;
        if (y0 < ey1) ey1 = y0;
        if (yl > ey2) ey2 = yl;
    endtask

    task automatic chk_dirty(input string req);
        chk(dirty_x1 == 11'(ex1) && dirty_x2 == 11'(ex2), req, "dirty x1/x2",
            {dirty_x1, dirty_x2}, {11'(ex1), 11'(ex2)});
        chk(dirty_y1 == 10'(ey1) && dirty_y2 == 10'(ey2), req, "dirty y1/y2",
            {dirty_y1, dirty_y2}, {10'(ey1), 10'(ey2)});
    endtask

    // Called at a negedge; returns at the negedge after the acceptance edge.
    task automatic launch(input logic [31:0] cmd, input logic [31:0] lw,
                          input logic [31:0] attr, input logic [31:0] v1,
                          input logic [31:0] v2, input logic m24);
        pkt_cmd = cmd; pkt_lw = lw; pkt_attr = attr;
        pkt_v1 = v1; pkt_v2 = v2; mode_24bpp = m24; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Follows the pixel stream; ends at the negedge where done is expected.
    task automatic watch(input int x0, input int xe, input int y0, input int yl,
                         input logic [23:0] data, input string req, input int inj);
        int k = 0;
        for (int y = y0; y <= yl; y++) begin
            for (int x = x0; x < xe; x++) begin
                chk(fb_we && fb_addr == 21'(y * XS + x) && fb_data == data, req,
                    "pixel we/addr/data", {fb_we, fb_addr, fb_data},
                    {1'b1, 21'(y * XS + x), data});
                if (k == inj) begin
                    pkt_v1 = mkv(0, 0); pkt_v2 = mkv(900, 900); start = 1'b1;
                end else if (k == inj + 1) begin
                    start = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(done && !fb_we, "R8", "done after last write", {done, fb_we}, 2'b10);
    endtask

    task automatic finish_quiet(input string req);
        @(negedge clk);
        chk(!done && !busy && !fb_we, req, "done single cycle, idle",
            {done, busy, fb_we}, 3'b000);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !fb_we, "R12", "reset outputs", {busy, done, fb_we}, 3'b000);
        chk_dirty("R10");
    endtask

    task automatic t_grey192_24bpp;
        // R2 R3 R5 R7: lw=3 -> q=1, rows 5..6, cols 10..13
        launch(32'h411, 32'd3, 32'h0007_0000, mkv(10, 5) + 32'd3, mkv(14, 6) + 32'd3, 1'b1);
        watch(10, 14, 5, 6, 24'hC0C0C0, "R5", -5);
        dirty_add(10, 14, 5, 6);
        finish_quiet("R8");
        chk_dirty("R10");
    endtask

    task automatic t_8bpp_borrow;
        // R2 R6: low bits borrow into Y: first Y becomes 4
        launch(32'h411, 32'd3, 32'h0000_095A, mkv(10, 5), mkv(12, 7) + 32'd3, 1'b0);
        watch(10, 12, 4, 7, 24'h00005A, "R6", -5);
        dirty_add(10, 12, 4, 7);
        finish_quiet("R8");
        chk_dirty("R10");
    endtask

    task automatic t_grey_other;
        // R5: selector 0 gives black, other values give full level
        launch(32'h411, 32'd0, 32'h0000_00FF, mkv(0, 0), mkv(1, 1), 1'b1);
        watch(0, 1, 0, 0, 24'h000000, "R5", -5);
        dirty_add(0, 1, 0, 0);
        finish_quiet("R8");
        launch(32'h411, 32'd0, 32'h0033_0000, mkv(2, 3), mkv(3, 4), 1'b1);
        watch(2, 3, 3, 3, 24'hFFFFFF, "R5", -5);
        dirty_add(2, 3, 3, 3);
        finish_quiet("R8");
        chk_dirty("R10");
    endtask

    task automatic t_wrong_cmd;
        // R1: code 0x410 is ignored
        launch(32'h410, 32'd0, 32'h0007_0000, mkv(5, 5), mkv(9, 9), 1'b1);
        for (int i = 0; i < 4; i++) begin
            chk(!busy && !done && !fb_we, "R1", "no activity on wrong code",
                {busy, done, fb_we}, 3'b000);
            @(negedge clk);
        end
        chk_dirty("R1");
    endtask

    task automatic t_clamp;
        // R4: span 2000 > 1280, columns end at 1280
        launch(32'h411, 32'd0, 32'h0000_0011, mkv(0, 1000), mkv(2000, 1001), 1'b0);
        watch(0, 1280, 1000, 1000, 24'h000011, "R4", -5);
        dirty_add(0, 1280, 1000, 1000);
        finish_quiet("R8");
        chk_dirty("R4");
    endtask

    task automatic t_empty;
        // R8: zero width, no writes, done next cycle, dirty unchanged
        launch(32'h411, 32'd0, 32'h0000_0022, mkv(50, 50), mkv(50, 60), 1'b0);
        watch(50, 50, 50, 59, 24'h000022, "R8", -5);
        finish_quiet("R8");
        chk_dirty("R10");
    endtask

    task automatic t_row_clip;
        // R3: lw=11 -> q=3, end row 1026 clipped to last row 1023
        launch(32'h411, 32'd11, 32'h0000_0044, mkv(0, 1022) + 32'd11,
               mkv(3, 1023) + 32'd11, 1'b0);
        watch(0, 3, 1022, 1023, 24'h000044, "R3", -5);
        dirty_add(0, 3, 1022, 1023);
        finish_quiet("R8");
        chk_dirty("R3");
    endtask

    task automatic t_neg_lw;
        // R3: lw=-4 -> q=-1, rows 10..11
        launch(32'h411, 32'hFFFF_FFFC, 32'h0000_0066, mkv(5, 10) + 32'hFFFF_FFFC,
               mkv(7, 13) + 32'hFFFF_FFFC, 1'b0);
        watch(5, 7, 10, 11, 24'h000066, "R3", -5);
        finish_quiet("R8");
    endtask

    task automatic t_start_while_busy;
        // R9: start raised during the stream is ignored
        launch(32'h411, 32'd0, 32'h0005_0000, mkv(60, 70), mkv(63, 72), 1'b1);
        watch(60, 63, 70, 71, 24'hFFFFFF, "R9", 1);
        finish_quiet("R9");
    endtask

    task automatic t_back_to_back;
        // R11: second command raised on the done cycle
        launch(32'h411, 32'd0, 32'h0000_0022, mkv(20, 30), mkv(22, 31), 1'b0);
        watch(20, 22, 30, 30, 24'h000022, "R11", -5);
        launch(32'h411, 32'd0, 32'h0007_0000, mkv(40, 31), mkv(41, 33), 1'b1);
        watch(40, 41, 31, 32, 24'hC0C0C0, "R11", -5);
        finish_quiet("R11");
        chk_dirty("R11");
    endtask

    initial begin
        #(20ns * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grey192_24bpp();
        t_8bpp_borrow();
        t_grey_other();
        t_wrong_cmd();
        t_clamp();
        t_empty();
        t_row_clip();
        t_neg_lw();
        t_start_while_busy();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule